// File: doc/BRIEF.md
# Per-Core Countdown Timer

This block is the countdown timer that sits beside a core's local interrupt controller. Software programs a divider code, a control word (periodic or one-shot, interrupt mask) and an initial count through a small write port. Writing the initial count loads the current count and restarts a free-running prescaler. The current count then drops by one on each divided tick, where a tick comes every 2^shift clock cycles. When the count steps from one to zero, the timer expires and raises a one-cycle interrupt request toward the core's request logic, unless the mask bit is set.

A four-state machine controls the count. OFF is entered when the initial count written is zero. COUNT is entered on a non-zero write. On the tick that takes the count from 1 to 0, COUNT moves to WRAP in periodic mode or to DONE in one-shot mode ("expire"). WRAP holds zero for one divided period and then goes back to COUNT with the count reloaded ("reload"). If one-shot mode was selected in the meantime, WRAP goes to DONE instead. DONE holds zero until the next initial-count write ("restart"), which leaves any state. An undecodable divider code stops all ticks and sets the flag output div_bad.

Top module: `core_tick_timer`

## Requirements
- R1: With an initial count of zero the timer stays in OFF. cur_count reads 0 and tmr_irq stays low.
- R2: A write with wr_sel = 0 loads wr_data into the initial and current counts and clears the prescaler. cur_count shows the value in the next cycle, and the first decrement follows 2^shift cycles later.
- R3: Divider code (wr_sel = 1, wr_data[3:0]) values 0 to 7 give shift = code, so the count drops once every 2^code cycles. Codes 8 to 15 raise div_bad, and cur_count holds.
- R4: When the count steps from 1 to 0, cur_count reads 0 and tmr_irq is high for exactly that first cycle at zero.
- R5: In one-shot mode (control bit 0 = 0), cur_count stays 0 after expiry and no further interrupt occurs until the next initial-count write.
- R6: In periodic mode (control bit 0 = 1), the count reloads from the initial count 2^shift cycles after reaching zero, so expiries repeat every (init+1)·2^shift cycles.
- R7: With the mask bit set (wr_sel = 2, wr_data bit 1 = 1), expiry raises no interrupt while the count sequence is unchanged.
- R8: An initial-count write on the same clock edge as an expiry takes precedence. The new value is loaded and no interrupt is raised.
- R9: After reset cur_count = 0, tmr_irq = 0 and div_bad = 0. The divider code is 0, the mode is one-shot and the mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 initial count, 1 divider code, 2 control, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| tmr_irq | output | 1 | One-cycle timer interrupt request |
| div_bad | output | 1 | Divider code does not decode |

## Verification
Two functions can fall on the same clock edge: an initial-count write and the expiry of a running count. The bench runs a periodic count whose expiry edge it computes from the initial count and shift. It places the write so that the write is captured on exactly that edge. It then expects the new count to be visible with the interrupt low, and expects the count to run again from a fresh prescaler phase. Random trials also change the mode and mask against a cycle-exact model of the count sequence.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_WRAP  = 2'd2,
        ST_DONE  = 2'd3
    } ctt_state_e;

    localparam logic [1:0] SEL_INIT = 2'd0;
    localparam logic [1:0] SEL_DIV  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
endpackage

// File: rtl/ctt_div_decode.sv
module ctt_div_decode #(
    parameter int DIV_W     = 4,
    parameter int MAX_SHIFT = 7,
    parameter int SHIFT_W   = $clog2(MAX_SHIFT + 1)
) (
    input  logic [DIV_W-1:0]   code_i,
    output logic [SHIFT_W-1:0] shift_o,
    output logic               valid_o
);
    always_comb begin
        valid_o = (code_i <= DIV_W'(MAX_SHIFT));
        shift_o = valid_o ? SHIFT_W'(code_i) : '0;
    end
endmodule

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
    parameter int MAX_SHIFT = 7,
    parameter int SHIFT_W   = $clog2(MAX_SHIFT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart_i,
    input  logic               valid_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic               tick_o
);
    localparam int PRE_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;

    always_comb begin
        span   = ((PRE_W+1)'(1) << shift_i) - (PRE_W+1)'(1);
        tick_o = valid_i && ((pre_q & span[PRE_W-1:0]) == span[PRE_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pre_q <= '0;
        else if (restart_i || !valid_i) pre_q <= '0;
        else                            pre_q <= pre_q + PRE_W'(1);
    end

    // R3: an undecodable divider parks the prescaler
    p_hold_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> pre_q == '0);
endmodule

// File: rtl/ctt_count_fsm.sv
module ctt_count_fsm
    import ctt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             tick_i,
    input  logic             periodic_i,
    input  logic             mask_i,
    output logic [CNT_W-1:0] cur_o,
    output logic             irq_o
);
    ctt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cur_q, cur_d, init_q;
    logic             irq_q, irq_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cur_q   <= '0;
            init_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            irq_q   <= irq_d;
            if (load_i) init_q <= load_val_i;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        irq_d   = 1'b0;
        if (load_i) begin
            cur_d   = load_val_i;
            state_d = (load_val_i == '0) ? ST_OFF : ST_COUNT;
        end else begin
            unique case (state_q)
                ST_OFF: ;
                ST_COUNT: begin
                    if (tick_i) begin
                        if (cur_q == CNT_W'(1)) begin
                            cur_d   = '0;
                            irq_d   = !mask_i;
                            state_d = periodic_i ? ST_WRAP : ST_DONE;
                        end else begin
                            cur_d = cur_q - CNT_W'(1);
                        end
                    end
                end
                ST_WRAP: begin
                    if (tick_i) begin
                        if (periodic_i) begin
                            cur_d   = init_q;
                            state_d = ST_COUNT;
                        end else begin
                            state_d = ST_DONE;
                        end
                    end
                end
                ST_DONE: ;
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign cur_o = cur_q;
    assign irq_o = irq_q;

    p_off_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !load_i) |=> (cur_q == '0 && !irq_q));
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cur_q == $past(load_val_i) && !irq_q)); // also R8
    p_irq_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> cur_q == '0);
    p_done_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !load_i) |=> (cur_q == '0 && !irq_q));
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WRAP |-> cur_q == '0);
    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> !irq_q);
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import ctt_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int DIV_W     = 4,
    parameter int MAX_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cur_count,
    output logic             tmr_irq,
    output logic             div_bad
);
    localparam int SHIFT_W = $clog2(MAX_SHIFT + 1);

    logic [DIV_W-1:0]   div_code_q;
    logic               periodic_q, mask_q;
    logic [SHIFT_W-1:0] shift;
    logic               div_ok, tick, load;

    assign load = wr_en && (wr_sel == SEL_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_code_q <= '0;
            periodic_q <= 1'b0;
            mask_q     <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DIV) div_code_q <= wr_data[DIV_W-1:0];
            if (wr_sel == SEL_CTRL) begin
                periodic_q <= wr_data[0];
                mask_q     <= wr_data[1];
            end
        end
    end

    ctt_div_decode #(.DIV_W(DIV_W), .MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_dec (
        .code_i (div_code_q),
        .shift_o(shift),
        .valid_o(div_ok)
    );

    ctt_prescale #(.MAX_SHIFT(MAX_SHIFT), .SHIFT_W(SHIFT_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(load),
        .valid_i  (div_ok),
        .shift_i  (shift),
        .tick_o   (tick)
    );

    ctt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .load_val_i(wr_data),
        .tick_i    (tick),
        .periodic_i(periodic_q),
        .mask_i    (mask_q),
        .cur_o     (cur_count),
        .irq_o     (tmr_irq)
    );

    assign div_bad = !div_ok;

    p_bad_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div_bad && !load) |=> $stable(cur_count));
endmodule

// File: tb/core_tick_timer_bench.sv
module core_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic        tmr_irq, div_bad;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    core_tick_timer u_core_tick_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cur_count(cur_count), .tmr_irq(tmr_irq), .div_bad(div_bad)
    );

    function automatic int m_cur(int c, int init, int s, bit per, bit ok);
        int n;
        if (!ok || init == 0) return init;
        n = c >> s;
        if (per) return init - (n % (init + 1));
        return (n >= init) ? 0 : init - n;
    endfunction

    function automatic bit m_irq(int c, int init, int s, bit per, bit msk, bit ok);
        int n;
        if (!ok || init == 0 || msk) return 1'b0;
        if ((c & ((1 << s) - 1)) != 0) return 1'b0;
        n = c >> s;
        if (per) return (n % (init + 1)) == init;
        return n == init;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n, int init, int s, bit per, bit msk, bit ok, string tag);
        for (int c = 0; c < n; c++) begin
            chk({tag, " count"}, int'(cur_count), m_cur(c, init, s, per, ok));
            chk({tag, " irq"}, int'(tmr_irq), int'(m_irq(c, init, s, per, msk, ok)));
            chk({tag, " div_bad"}, int'(div_bad), int'(!ok));
            @(negedge clk);
        end
    endtask

    task automatic setup(int code, bit per, bit msk);
        wr(2'd1, 32'(code));
        wr(2'd2, {30'd0, msk, per});
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset count", int'(cur_count), 0);
        chk("R9 reset irq", int'(tmr_irq), 0);
        chk("R9 reset div_bad", int'(div_bad), 0);
        // R9 defaults: one-shot, shift 0, unmasked; R2 R4 R5
        wr(2'd0, 32'd3);
        run(10, 3, 0, 0, 0, 1, "R9/R2/R4/R5 default one-shot");
        // R1 zero initial count
        wr(2'd0, 32'd0);
        run(8, 0, 0, 0, 0, 1, "R1 zero init");
        // R3 + R6 periodic with divide by 4
        setup(2, 1, 0);
        wr(2'd0, 32'd2);
        run(30, 2, 2, 1, 0, 1, "R3/R6 periodic div4");
        // R7 mask
        setup(1, 1, 1);
        wr(2'd0, 32'd3);
        run(20, 3, 1, 1, 1, 1, "R7 masked periodic");
        // R3 invalid divider
        setup(9, 0, 0);
        wr(2'd0, 32'd4);
        run(20, 4, 0, 0, 0, 0, "R3 invalid divider");
        // R5 one-shot divide by 8
        setup(3, 0, 0);
        wr(2'd0, 32'd2);
        run(40, 2, 3, 0, 0, 1, "R5 one-shot div8");
        // R8 write on the expiry edge (expiry at cycle 6)
        setup(1, 1, 0);
        wr(2'd0, 32'd3);
        run(5, 3, 1, 1, 0, 1, "R8 pre-collision");
        wr(2'd0, 32'd5);
        run(30, 5, 1, 1, 0, 1, "R8 write wins");
        // random trials
        for (int t = 0; t < 40; t++) begin
            int s, init, code;
            bit per, msk, ok;
            s    = int'($urandom_range(0, 3));
            init = int'($urandom_range(0, 6));
            per  = 1'($urandom_range(0, 1));
            msk  = 1'($urandom_range(0, 1));
            ok   = ($urandom_range(0, 7) != 0);
            code = ok ? s : int'($urandom_range(8, 15));
            setup(code, per, msk);
            wr(2'd0, 32'(init));
            run(((init + 1) << s) * 2 + 3, init, s, per, msk, ok, "R3/R6 random trial");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule